// File: doc/BRIEF.md
# Crossbar Request-Grant-Accept Scheduler

This block is the central arbiter for a square cell crossbar (16 ports by default). Once per cell period, marked by a one-cycle `cell_tick` strobe, each input presents a bitmap of the outputs for which its virtual output queues hold a cell. Each output that is not under backpressure grants one requester. Each input then accepts among the grants it received. The result is registered as the crossbar setting for the coming cell time: for every output, a valid bit and the index of the input that drives it. An input and an output on the same line card are just another port pair, so loopback goes through the crossbar like any other connection.

Multicast is served by partial fulfilment. When an input's head cell is multicast, it asks for every output in its fanout mask. It accepts every grant it gets, so one input can drive several outputs in the same period. Outputs that were not won stay in a residual mask, and they are requested again in later periods. While the residual mask is non-empty, the cell holds the head of that input: the input's unicast requests and any new multicast load are set aside.

The grant and accept choices both use rotating round-robin pointers. A pointer moves only when a match is actually made, so no requester can be starved. Each input sends at most one cell per period, and each output receives at most one.

Top module: `xbar_rga_sched`

## Requirements
- R1: While reset is asserted and after it is released, before the first `cell_tick`, `cfg_valid` and `mc_pend` are all zero.
- R2: `cfg_valid` and `cfg_src` change only at a clock edge where `cell_tick` is high, and hold their values between ticks.
- R3: An output is connected only to an input that requested it in that period. The unicast request of input i for output o is bit `i*N+o` of `voq_req`. Among the requesters, the output grants the first one at or after its grant pointer, in increasing index order with wrap-around.
- R4: A unicast input accepts exactly one of its grants: the first granting output at or after its accept pointer. No unicast input drives more than one output in a period.
- R5: After a match, the output's grant pointer moves to one past the matched input. After a unicast match, the input's accept pointer moves to one past the matched output. A grant that is not accepted leaves both pointers unchanged.
- R6: An output with `out_bp` high at the tick gets no connection in that period.
- R7: A multicast cell is loaded from the fanout mask of input i (bits `i*N +: N` of `mc_fanout`) when `mc_new[i]` is high at a tick and no residual is pending. The input accepts every grant from outputs in its mask. The outputs it did not win remain pending, and `mc_pend[i]` stays high until none remain.
- R8: While `mc_pend[i]` is high, `mc_new[i]`, the new fanout and the unicast requests of input i have no effect.
- R9: Input i may be matched to output i.
- R10: Service rotates fairly. k inputs contending for one output are each served once every k periods. Under full load, every input is matched in most periods.
- R11: Output o's source index is `cfg_src[o*W +: W]`, and it is zero when `cfg_valid[o]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cell_tick | input | 1 | One-cycle strobe that starts a cell period |
| voq_req | input | N*N | Unicast requests, bit i*N+o = input i holds a cell for output o |
| mc_new | input | N | Input i offers a new multicast head cell |
| mc_fanout | input | N*N | Fanout mask of the offered multicast cell, bits i*N +: N |
| out_bp | input | N | Per-output backpressure |
| cfg_valid | output | N | Output o is connected this cell period |
| cfg_src | output | N*W | Input index driving output o, bits o*W +: W |
| mc_pend | output | N | Input i holds a multicast cell with residual fanout |

## Verification
The checker enforces the following on every cycle:
- the configuration holds between ticks;
- a backpressured output is never connected;
- every connection traces back to a request latched at the tick;
- a unicast input never drives two outputs;
- a multicast pending flag only rises on a tick that loaded a new cell.

Pointer order, one-past advancement, exact round-robin rotation and the residual mask draining over several periods depend on history across many periods. Only the bench shows these, by comparing each cycle against a behavioural reference model and by running directed contention, loopback and multicast scenarios.

// File: rtl/xbs_pkg.sv
package xbs_pkg;
   localparam int unsigned XBS_MAX_PORTS = 64;

   // next position of a round-robin pointer, wrapping at n
   function automatic int unsigned xbs_wrap_inc(int unsigned v, int unsigned n);
      return (v + 1 >= n) ? 0 : v + 1;
   endfunction
endpackage

// File: rtl/xbs_rr_pick.sv
module xbs_rr_pick #(
   parameter int unsigned N = 16,
   parameter int unsigned W = 4
) (
   input  logic [N-1:0] req,
   input  logic [W-1:0] ptr,
   output logic [N-1:0] pick,
   output logic [W-1:0] idx,
   output logic         hit
);
   localparam int unsigned SW = W + 1;

   logic [SW-1:0] cand;

   // first request at or after ptr, wrapping around
   always_comb begin
      pick = '0;
      idx  = '0;
      hit  = 1'b0;
      cand = '0;
      for (int k = 0; k < N; k++) begin
         cand = SW'(ptr) + SW'(k);
         if (cand >= SW'(N)) cand = cand - SW'(N);
         if (!hit && req[cand[W-1:0]]) begin
            hit              = 1'b1;
            idx              = cand[W-1:0];
            pick[cand[W-1:0]] = 1'b1;
         end
      end
   end
endmodule

// File: rtl/xbs_mc_head.sv
module xbs_mc_head #(
   parameter int unsigned N = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         tick,
   input  logic         load,
   input  logic [N-1:0] fanout,
   input  logic [N-1:0] served,
   output logic [N-1:0] mask,
   output logic         pend
);
   logic [N-1:0] resid_q;

   // a pending residual blocks any new cell
   assign mask = (resid_q != '0) ? resid_q : (load ? fanout : '0);
   assign pend = |resid_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    resid_q <= '0;
      else if (tick) resid_q <= mask & ~served;
   end
endmodule

// File: rtl/xbar_rga_sched.sv
module xbar_rga_sched import xbs_pkg::*; #(
   parameter int unsigned N     = 16,
   parameter int unsigned W     = $clog2(N),
   parameter bit          MC_EN = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           cell_tick,
   input  logic [N*N-1:0] voq_req,
   input  logic [N-1:0]   mc_new,
   input  logic [N*N-1:0] mc_fanout,
   input  logic [N-1:0]   out_bp,
   output logic [N-1:0]   cfg_valid,
   output logic [N*W-1:0] cfg_src,
   output logic [N-1:0]   mc_pend
);
   if (N < 2 || N > XBS_MAX_PORTS) begin : g_bad_n
      $error("xbar_rga_sched: N out of range");
   end
   if ((1 << W) < N) begin : g_bad_w
      $error("xbar_rga_sched: W too narrow for N");
   end

   logic [N-1:0] mc_mask [N];
   logic [N-1:0] is_mc;
   logic [N-1:0] req_row [N];
   logic [N-1:0] col     [N];
   logic [N-1:0] gnt_col [N];
   logic [W-1:0] gidx    [N];
   logic [N-1:0] ghit;
   logic [N-1:0] gin     [N];
   logic [N-1:0] apick   [N];
   logic [W-1:0] aidx    [N];
   logic [N-1:0] ahit;
   logic [N-1:0] acc_row [N];
   logic [N-1:0] acc_col [N];
   logic [N-1:0] won;
   logic [W-1:0] gptr_q  [N];
   logic [W-1:0] aptr_q  [N];

   // per-input head: multicast residual (variant) and request row
   for (genvar i = 0; i < N; i++) begin : g_in
      if (MC_EN) begin : g_mc
         xbs_mc_head #(.N(N)) head_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .tick   (cell_tick),
            .load   (mc_new[i]),
            .fanout (mc_fanout[i*N +: N]),
            .served (acc_row[i]),
            .mask   (mc_mask[i]),
            .pend   (mc_pend[i])
         );
      end else begin : g_nomc
         assign mc_mask[i] = '0;
         assign mc_pend[i] = 1'b0;
      end
      assign is_mc[i]   = |mc_mask[i];
      assign req_row[i] = is_mc[i] ? mc_mask[i] : voq_req[i*N +: N];
   end

   // request phase seen from outputs, with backpressure
   always_comb begin
      for (int o = 0; o < N; o++)
         for (int i = 0; i < N; i++)
            col[o][i] = req_row[i][o] & ~out_bp[o];
   end

   // grant phase
   for (genvar o = 0; o < N; o++) begin : g_gnt
      xbs_rr_pick #(.N(N), .W(W)) garb_i (
         .req  (col[o]),
         .ptr  (gptr_q[o]),
         .pick (gnt_col[o]),
         .idx  (gidx[o]),
         .hit  (ghit[o])
      );
   end

   always_comb begin
      for (int i = 0; i < N; i++)
         for (int o = 0; o < N; o++)
            gin[i][o] = gnt_col[o][i];
   end

   // accept phase: unicast picks one, multicast takes all
   for (genvar i = 0; i < N; i++) begin : g_acc
      xbs_rr_pick #(.N(N), .W(W)) aarb_i (
         .req  (gin[i]),
         .ptr  (aptr_q[i]),
         .pick (apick[i]),
         .idx  (aidx[i]),
         .hit  (ahit[i])
      );
      assign acc_row[i] = is_mc[i] ? gin[i] : apick[i];
   end

   always_comb begin
      for (int o = 0; o < N; o++) begin
         for (int i = 0; i < N; i++)
            acc_col[o][i] = acc_row[i][o];
         won[o] = ghit[o] & (|acc_col[o]);
      end
   end

   // configuration and pointer registers
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_valid <= '0;
         cfg_src   <= '0;
         for (int o = 0; o < N; o++) gptr_q[o] <= '0;
         for (int i = 0; i < N; i++) aptr_q[i] <= '0;
      end else if (cell_tick) begin
         for (int o = 0; o < N; o++) begin
            cfg_valid[o]         <= won[o];
            cfg_src[o*W +: W]    <= won[o] ? gidx[o] : '0;
            if (won[o]) gptr_q[o] <= W'(xbs_wrap_inc(32'(gidx[o]), N));
         end
         for (int i = 0; i < N; i++) begin
            if (!is_mc[i] && ahit[i])
               aptr_q[i] <= W'(xbs_wrap_inc(32'(aidx[i]), N));
         end
      end
   end
endmodule

// File: rtl/xbs_sched_chk.sv
module xbs_sched_chk #(
   parameter int unsigned N = 16,
   parameter int unsigned W = 4
) (
   input logic           clk,
   input logic           rst_n,
   input logic           cell_tick,
   input logic [N*N-1:0] voq_req,
   input logic [N-1:0]   mc_new,
   input logic [N-1:0]   out_bp,
   input logic [N-1:0]   cfg_valid,
   input logic [N*W-1:0] cfg_src,
   input logic [N-1:0]   mc_pend
);
   logic           tick_q;
   logic [N*N-1:0] req_q;
   logic [N-1:0]   mcn_q, pend_q;
   logic [N-1:0]   dup;
   logic [W:0]     cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tick_q <= 1'b0;
         req_q  <= '0;
         mcn_q  <= '0;
         pend_q <= '0;
      end else begin
         tick_q <= cell_tick;
         if (cell_tick) begin
            req_q  <= voq_req;
            mcn_q  <= mc_new;
            pend_q <= mc_pend;
         end
      end
   end

   always_comb begin
      dup = '0;
      cnt = '0;
      for (int i = 0; i < N; i++) begin
         cnt = '0;
         for (int o = 0; o < N; o++)
            if (cfg_valid[o] && cfg_src[o*W +: W] == W'(i)) cnt = cnt + 1'b1;
         dup[i] = (cnt > 1) && !(pend_q[i] || mcn_q[i]);
      end
   end

   // R2
   a_r2_cfg_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !cell_tick |=> $stable(cfg_valid) && $stable(cfg_src));

   // R3
   a_r3_idle_no_req: assert property (@(posedge clk) disable iff (!rst_n)
      cell_tick && voq_req == '0 && mc_new == '0 && mc_pend == '0 |=> cfg_valid == '0);

   // R4
   a_r4_one_cell_per_input: assert property (@(posedge clk) disable iff (!rst_n)
      tick_q |-> dup == '0);

   for (genvar o = 0; o < N; o++) begin : g_out
      // R6
      a_r6_bp_no_grant: assert property (@(posedge clk) disable iff (!rst_n)
         cell_tick && out_bp[o] |=> !cfg_valid[o]);
      // R3
      a_r3_src_requested: assert property (@(posedge clk) disable iff (!rst_n)
         tick_q && cfg_valid[o] |->
            (req_q[int'(cfg_src[o*W +: W])*N + o] ||
             pend_q[cfg_src[o*W +: W]] || mcn_q[cfg_src[o*W +: W]]));
   end

   for (genvar i = 0; i < N; i++) begin : g_inp
      // R7
      a_r7_pend_from_load: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(mc_pend[i]) |-> $past(cell_tick && mc_new[i]));
   end
endmodule

bind xbar_rga_sched xbs_sched_chk #(.N(N), .W(W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .cell_tick (cell_tick),
   .voq_req   (voq_req),
   .mc_new    (mc_new),
   .out_bp    (out_bp),
   .cfg_valid (cfg_valid),
   .cfg_src   (cfg_src),
   .mc_pend   (mc_pend)
);

// File: tb/xbar_rga_sched_tb_top.sv
module xbar_rga_sched_tb_top;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int N = 16;
   localparam int W = 4;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cell_tick = 1'b0;
   logic [N*N-1:0] voq_req = '0;
   logic [N-1:0]   mc_new = '0;
   logic [N*N-1:0] mc_fanout = '0;
   logic [N-1:0]   out_bp = '0;
   logic [N-1:0]   cfg_valid;
   logic [N*W-1:0] cfg_src;
   logic [N-1:0]   mc_pend;

   always #5 clk = ~clk;

   xbar_rga_sched #(.N(N), .W(W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cell_tick(cell_tick), .voq_req(voq_req),
      .mc_new(mc_new), .mc_fanout(mc_fanout), .out_bp(out_bp),
      .cfg_valid(cfg_valid), .cfg_src(cfg_src), .mc_pend(mc_pend)
   );

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   // reference model state
   int           gp [N];
   int           ap [N];
   logic [N-1:0] res [N];
   logic [N-1:0] e_valid = '0;
   logic [N-1:0] e_pend = '0;
   int           e_src [N];

   task automatic chk(bit ok, string req, string what, longint act, longint exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int src_of(int o);
      return int'(cfg_src[o*W +: W]);
   endfunction

   task automatic model_tick();
      logic [N-1:0] row [N];
      logic [N-1:0] take [N];
      bit           mcf [N];
      int           gsel [N];
      for (int i = 0; i < N; i++) begin
         logic [N-1:0] m;
         m = (res[i] != '0) ? res[i] : (mc_new[i] ? mc_fanout[i*N +: N] : '0);
         mcf[i] = (m != '0);
         row[i] = mcf[i] ? m : voq_req[i*N +: N];
      end
      for (int o = 0; o < N; o++) begin
         gsel[o] = -1;
         if (!out_bp[o])
            for (int k = 0; k < N; k++) begin
               int c = (gp[o] + k) % N;
               if (gsel[o] < 0 && row[c][o]) gsel[o] = c;
            end
      end
      for (int i = 0; i < N; i++) begin
         take[i] = '0;
         if (mcf[i]) begin
            for (int o = 0; o < N; o++) if (gsel[o] == i) take[i][o] = 1'b1;
         end else begin
            for (int k = 0; k < N; k++) begin
               int o = (ap[i] + k) % N;
               if (take[i] == '0 && gsel[o] == i) begin
                  take[i][o] = 1'b1;
                  ap[i] = (o + 1) % N;
               end
            end
         end
      end
      for (int o = 0; o < N; o++) begin
         e_valid[o] = 1'b0;
         e_src[o] = 0;
         for (int i = 0; i < N; i++)
            if (take[i][o]) begin
               e_valid[o] = 1'b1;
               e_src[o] = i;
               gp[o] = (i + 1) % N;
            end
      end
      for (int i = 0; i < N; i++) begin
         res[i] = mcf[i] ? (row[i] & ~take[i]) : '0;
         e_pend[i] = (res[i] != '0);
      end
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) begin
            gp[i] = 0; ap[i] = 0; res[i] = '0; e_src[i] = 0;
         end
         e_valid = '0;
         e_pend = '0;
      end else if (cell_tick) begin
         model_tick();
      end
   end

   // per-cycle comparison against the model (R2 R3 R4 R5 R7 R11)
   always @(negedge clk) begin
      if (rst_n && !done) begin
         bit ok = (cfg_valid == e_valid) && (mc_pend == e_pend);
         for (int o = 0; o < N; o++)
            if (src_of(o) != (e_valid[o] ? e_src[o] : 0)) ok = 1'b0;
         chk(ok, "R5", "model valid", longint'(cfg_valid), longint'(e_valid));
      end
   end

   task automatic tick();
      @(negedge clk) cell_tick = 1'b1;
      @(negedge clk) cell_tick = 1'b0;
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int cnt [N];
      int prev;
      repeat (3) @(negedge clk);
      chk(cfg_valid == '0 && mc_pend == '0, "R1", "during reset", longint'(cfg_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(cfg_valid == '0 && mc_pend == '0, "R1", "after reset", longint'(cfg_valid), 0);

      // full request from reset pointers: only input0->output0
      voq_req = '1;
      tick();
      chk(cfg_valid == 16'h0001, "R4", "first full period", longint'(cfg_valid), 1);
      chk(src_of(0) == 0, "R3", "first grant source", src_of(0), 0);

      // no tick: configuration holds
      voq_req = '0;
      voq_req[5*N + 9] = 1'b1;
      out_bp = 16'h0001;
      repeat (3) @(negedge clk);
      chk(cfg_valid == 16'h0001, "R2", "hold without tick", longint'(cfg_valid), 1);
      out_bp = '0;

      // full load fairness
      voq_req = '1;
      for (int i = 0; i < N; i++) cnt[i] = 0;
      for (int p = 0; p < 64; p++) begin
         tick();
         for (int o = 0; o < N; o++) if (cfg_valid[o]) cnt[src_of(o)]++;
      end
      for (int i = 0; i < N; i++)
         chk(cnt[i] >= 32, "R10", $sformatf("full load input %0d", i), cnt[i], 32);

      // loopback
      voq_req = '0;
      voq_req[3*N + 3] = 1'b1;
      tick();
      chk(cfg_valid == 16'h0008 && src_of(3) == 3, "R9", "loopback", longint'(cfg_valid), 8);

      // backpressure
      voq_req = '0;
      voq_req[1*N + 2] = 1'b1;
      out_bp[2] = 1'b1;
      tick();
      chk(cfg_valid == '0, "R6", "blocked output", longint'(cfg_valid), 0);
      out_bp = '0;
      tick();
      chk(cfg_valid == 16'h0004 && src_of(2) == 1, "R6", "released output", longint'(cfg_valid), 4);

      // rotation on one contended output
      voq_req = '0;
      for (int i = 0; i < 4; i++) voq_req[i*N + 5] = 1'b1;
      for (int i = 0; i < N; i++) cnt[i] = 0;
      prev = -1;
      for (int p = 0; p < 8; p++) begin
         tick();
         chk(cfg_valid == 16'h0020, "R3", "contended output", longint'(cfg_valid), 32);
         chk(src_of(5) != prev, "R5", "pointer moved", src_of(5), prev);
         prev = src_of(5);
         cnt[prev]++;
      end
      for (int i = 0; i < 4; i++)
         chk(cnt[i] == 2, "R10", $sformatf("rotation input %0d", i), cnt[i], 2);

      // multicast partial fulfilment
      voq_req = '0;
      mc_new[2] = 1'b1;
      mc_fanout[2*N + 1] = 1'b1;
      mc_fanout[2*N + 4] = 1'b1;
      mc_fanout[2*N + 7] = 1'b1;
      out_bp[7] = 1'b1;
      tick();
      chk(cfg_valid == 16'h0012 && src_of(1) == 2 && src_of(4) == 2, "R7", "partial fanout",
          longint'(cfg_valid), 18);
      chk(mc_pend == 16'h0004, "R7", "residual pending", longint'(mc_pend), 4);
      mc_fanout = '0;
      mc_fanout[2*N + 9] = 1'b1;
      voq_req[2*N + 12] = 1'b1;
      out_bp = '0;
      tick();
      chk(cfg_valid == 16'h0080 && src_of(7) == 2, "R7", "deferred copy", longint'(cfg_valid), 128);
      chk(!cfg_valid[9] && !cfg_valid[12], "R8", "head blocks new load", longint'(cfg_valid), 128);
      chk(mc_pend == '0, "R7", "residual drained", longint'(mc_pend), 0);
      mc_new = '0;
      mc_fanout = '0;
      voq_req = '0;

      // random traffic against the model
      for (int p = 0; p < 300; p++) begin
         for (int w = 0; w < N*N/32; w++) voq_req[w*32 +: 32] = $urandom() & $urandom();
         out_bp = N'($urandom() & $urandom() & $urandom());
         mc_new = N'($urandom() & $urandom() & $urandom());
         for (int w = 0; w < N*N/32; w++) mc_fanout[w*32 +: 32] = $urandom();
         repeat ($urandom_range(0, 2)) @(negedge clk);
         tick();
      end

      done = 1'b1;
      summary();
      $finish;
   end
endmodule